// File: doc/BRIEF.md
# Five-Port XY Wormhole Router with Type-Framed Packets

This block switches 12-bit flits for one tile of a two-dimensional mesh. It has five ports: the local tile and four neighbours (North, East, South, West). Each input has a small FIFO. The flit at the head of that FIFO is steered by dimension-ordered routing: it corrects X first, then Y, and delivers locally when both match. Each output has a round-robin arbiter that chooses among the inputs asking for it. Once the arbiter presents a flit from an input, the output stays locked to that input until the last flit of that packet has gone through, so packets are never interleaved (wormhole forwarding).

Packets carry no length field and no tail bit. The framing comes from the 2-bit type code in bits [11:10] of each flit:

- A runtime packet, head type 00, is exactly two flits long.
- A configuration packet, head type 01, runs up to and including the first later flit whose type is 11.
- A head with any other type is a packet of one flit.

The tile's own coordinates come in on plain input pins. The destination coordinates sit in the low bits of the head flit.

Every data interface uses valid/ready. A flit moves on a clock edge where valid and ready are both high. A sender must keep valid and its flit steady until that edge. An input's ready depends only on its own FIFO fill level. An output that is presenting a flit keeps it, unchanged, for as long as ready stays low.

Top module: `mesh_router`

## Requirements
- R1: During and right after reset, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: Each input holds up to 4 flits. `in_ready` of a port is 0 exactly while 4 flits are buffered there. No accepted flit is lost, and flits leave an input in arrival order.
- R3: Head flit fields are destination X in bits [3:2] and destination Y in bits [1:0], compared with `my_x` and `my_y`:
  - dest X > `my_x` goes to East, dest X < `my_x` goes to West;
  - otherwise dest Y > `my_y` goes to North, dest Y < `my_y` goes to South;
  - otherwise the packet goes to Local.
  - Every later flit of the packet takes the head's path.
- R4: A head with type bits [11:10] = 00 opens a packet of exactly two flits. The content of the second flit, including its type bits, does not change the framing.
- R5: A head with type 01 opens a packet that includes every following flit up to and including the first flit whose bits [11:10] are 11. Body flits typed 00, 01 or 10 do not close it.
- R6: A head typed 10 or 11 is a packet of one flit.
- R7: Flits of two different packets never interleave on one output.
- R8: Port indices are Local 0, North 1, East 2, South 3, West 4. Each output's arbiter starts at priority index 0 after reset. Once it chooses input i, its search for the next packet starts at index i+1 and wraps.
- R9: While an output shows `out_valid` = 1 with `out_ready` = 0, on the next cycle `out_valid` stays 1 and the flit is unchanged.
- R10: Packets from different inputs bound for different outputs move in the same cycles without waiting for each other.
- R11: An output releases its lock on the edge that moves a packet's last flit. A contender that is waiting then sends its head flit on the very next cycle, with no idle cycle between the two packets.
- R12: A flit accepted at an input with its FIFO empty and its output free and ready appears on the output during the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | 2 | X coordinate of this tile |
| my_y | input | 2 | Y coordinate of this tile |
| in_valid | input | 5 | Per-port input flit valid (bit = port index) |
| in_flit | input | 60 | Input flits, port p in bits [12p+11:12p] |
| in_ready | output | 5 | Per-port input ready |
| out_valid | output | 5 | Per-port output flit valid |
| out_flit | output | 60 | Output flits, port p in bits [12p+11:12p] |
| out_ready | input | 5 | Per-port output ready from downstream |

## Verification
The release of an output's lock on a packet's last flit can coincide with the round-robin pick of the next packet from another input. This is provoked by having three inputs send packets to the Local port at the same moment. The result is judged on two things: the order of sources in the output stream, and whether the output transfers flits on consecutive cycles with no gap at packet boundaries.

A second test has two inputs contend for East with a mix of configuration, runtime and single-flit packets. If any framing rule is wrong, the arbiter switches inputs at the wrong flit, and the East output sequence shows the change.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
  localparam int NPORT = 5;
  localparam int PIW   = 3;

  typedef enum logic [PIW-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_EAST  = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;

  localparam logic [1:0] KIND_RUN = 2'b00;
  localparam logic [1:0] KIND_CFG = 2'b01;
  localparam logic [1:0] KIND_END = 2'b11;
endpackage

// File: rtl/rtr_fifo.sv
module rtr_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [W-1:0]    mem_q [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (wr_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) wp_q <= (wp_q == LAST_IDX) ? '0 : wp_q + 1'b1;
      if (rd_i) rp_q <= (rp_q == LAST_IDX) ? '0 : rp_q + 1'b1;
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> !full_o);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |-> !empty_o);
endmodule

// File: rtl/rtr_inport.sv
module rtr_inport
  import mesh_router_pkg::*;
#(
  parameter int FW    = 12,
  parameter int CW    = 2,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [FW-1:0]    in_flit_i,
  output logic             in_ready_o,
  input  logic [CW-1:0]    my_x_i,
  input  logic [CW-1:0]    my_y_i,
  input  logic             fwd_i,
  output logic [NPORT-1:0] req_o,
  output logic             last_o,
  output logic [FW-1:0]    flit_o
);
  logic [FW-1:0] head;
  logic          empty, full, have, pop, wr;
  logic [1:0]    kind;
  logic [CW-1:0] dx, dy;
  port_e         dir_head, dir, dir_q;
  logic          busy_q, cfg_q;

  assign wr         = in_valid_i & ~full;
  assign in_ready_o = ~full;
  assign have       = ~empty;
  assign pop        = fwd_i & have;

  rtr_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .wdata_i(in_flit_i),
    .rd_i(pop), .rdata_o(head), .empty_o(empty), .full_o(full)
  );

  assign kind = head[FW-1 -: 2];
  assign dx   = head[2*CW-1 -: CW];
  assign dy   = head[CW-1:0];

  always_comb begin
    if (dx > my_x_i)      dir_head = PORT_EAST;
    else if (dx < my_x_i) dir_head = PORT_WEST;
    else if (dy > my_y_i) dir_head = PORT_NORTH;
    else if (dy < my_y_i) dir_head = PORT_SOUTH;
    else                  dir_head = PORT_LOCAL;
  end

  assign dir = busy_q ? dir_q : dir_head;

  always_comb begin
    if (busy_q) last_o = cfg_q ? (kind == KIND_END) : 1'b1;
    else        last_o = (kind != KIND_RUN) && (kind != KIND_CFG);
  end

  assign req_o  = have ? (NPORT'(1) << dir) : '0;
  assign flit_o = head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cfg_q  <= 1'b0;
      dir_q  <= PORT_LOCAL;
    end else if (pop) begin
      if (last_o) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        busy_q <= 1'b1;
        cfg_q  <= (kind == KIND_CFG);
        dir_q  <= dir_head;
      end
    end
  end

  assert_path_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !last_o |=> !have || $stable(dir));
endmodule

// File: rtl/rtr_outarb.sv
module rtr_outarb
  import mesh_router_pkg::*;
#(
  parameter int N = NPORT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] last_i,
  input  logic         out_ready_i,
  output logic [N-1:0] gnt_o,
  output logic         valid_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);

  logic          lock_q;
  logic [IW-1:0] own_q, ptr_q, pick, sel;
  logic          found, any, xfer, tail;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (!found && req_i[j]) begin
        found = 1'b1;
        pick  = IW'(j);
      end
    end
  end

  assign sel     = lock_q ? own_q : pick;
  assign any     = lock_q ? req_i[own_q] : found;
  assign gnt_o   = any ? (N'(1) << sel) : '0;
  assign valid_o = any;
  assign xfer    = any & out_ready_i;
  assign tail    = last_i[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      own_q  <= '0;
      ptr_q  <= '0;
    end else if (any) begin
      own_q  <= sel;
      lock_q <= !(xfer && tail);
      if (!lock_q) ptr_q <= (sel == TOP_IDX) ? '0 : sel + 1'b1;
    end
  end

  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !tail |=> (gnt_o == '0) || (gnt_o == $past(gnt_o)));
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mesh_router_pkg::*;
#(
  parameter int FW    = 12,
  parameter int CW    = 2,
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       my_x,
  input  logic [CW-1:0]       my_y,
  input  logic [NPORT-1:0]    in_valid,
  input  logic [NPORT*FW-1:0] in_flit,
  output logic [NPORT-1:0]    in_ready,
  output logic [NPORT-1:0]    out_valid,
  output logic [NPORT*FW-1:0] out_flit,
  input  logic [NPORT-1:0]    out_ready
);
  logic [NPORT-1:0] req_w  [NPORT];
  logic [NPORT-1:0] reqc_w [NPORT];
  logic [NPORT-1:0] gnt_w  [NPORT];
  logic [NPORT-1:0] gntc_w [NPORT];
  logic [FW-1:0]    flit_w [NPORT];
  logic             last_w [NPORT];
  logic             rdy_w  [NPORT];
  logic             ovld_w [NPORT];
  logic             fwd_w  [NPORT];
  logic [NPORT-1:0] lastv;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    rtr_inport #(.FW(FW), .CW(CW), .DEPTH(DEPTH)) u_in (
      .clk(clk), .rst_n(rst_n),
      .in_valid_i(in_valid[i]), .in_flit_i(in_flit[i*FW +: FW]),
      .in_ready_o(rdy_w[i]), .my_x_i(my_x), .my_y_i(my_y),
      .fwd_i(fwd_w[i]), .req_o(req_w[i]), .last_o(last_w[i]),
      .flit_o(flit_w[i])
    );
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    rtr_outarb #(.N(NPORT)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_i(reqc_w[o]), .last_i(lastv),
      .out_ready_i(out_ready[o]), .gnt_o(gnt_w[o]), .valid_o(ovld_w[o])
    );
  end

  always_comb begin
    out_flit = '0;
    for (int i = 0; i < NPORT; i++) begin
      lastv[i]    = last_w[i];
      in_ready[i] = rdy_w[i];
      out_valid[i] = ovld_w[i];
      for (int o = 0; o < NPORT; o++) begin
        reqc_w[o][i] = req_w[i][o];
        gntc_w[i][o] = gnt_w[o][i];
      end
    end
    for (int i = 0; i < NPORT; i++) begin
      fwd_w[i] = |(gntc_w[i] & out_ready);
    end
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (gnt_w[o][i]) out_flit[o*FW +: FW] = out_flit[o*FW +: FW] | flit_w[i];
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_chk_out
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_flit[o*FW +: FW]));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk_in
    assert_one_sink_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gntc_w[i]));
  end
endmodule

// File: tb/sim_mesh_router.sv
`timescale 1ns/1ps
module sim_mesh_router;
  localparam int FW = 12, CW = 2, NP = 5, QD = 32;
  localparam int MX = 1, MY = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP-1:0]    in_valid = '0, out_ready = '1;
  logic [NP-1:0]    in_ready, out_valid;
  logic [NP*FW-1:0] in_flit = '0, out_flit;
  logic [CW-1:0]    mx = CW'(MX), my = CW'(MY);

  mesh_router u0 (
    .clk(clk), .rst_n(rst_n), .my_x(mx), .my_y(my),
    .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
    .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready)
  );

  logic [FW-1:0] sq [NP][QD];
  int            sn [NP], si [NP];
  logic [FW-1:0] rec [NP][QD];
  int            rcyc [NP][QD];
  int            rn [NP];
  logic [FW-1:0] ex [NP][QD];
  int            en [NP];
  int cyc = 0, n_chk = 0, n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < NP; o++) begin
        if (out_valid[o] && out_ready[o] && rn[o] < QD) begin
          rec[o][rn[o]]  = out_flit[o*FW +: FW];
          rcyc[o][rn[o]] = cyc;
          rn[o]++;
        end
      end
    end
  end

  task automatic drive(input int p);
    bit acc = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (acc) si[p]++;
      in_valid[p] = (si[p] < sn[p]);
      in_flit[p*FW +: FW] = (si[p] < QD) ? sq[p][si[p]] : '0;
      @(negedge clk);
      acc = in_valid[p] && in_ready[p];
    end
  endtask

  function automatic logic [FW-1:0] hd(input logic [1:0] k, input int tag, input int dx, input int dy);
    return {k, 6'(tag), 2'(dx), 2'(dy)};
  endfunction

  function automatic int xy_port(input int dx, input int dy);
    if (dx > MX) return 2;
    if (dx < MX) return 4;
    if (dy > MY) return 1;
    if (dy < MY) return 3;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic sq_add(input int p, input logic [FW-1:0] f);
    sq[p][sn[p]] = f;
    sn[p]++;
  endtask

  task automatic ex_add(input int o, input logic [FW-1:0] f);
    ex[o][en[o]] = f;
    en[o]++;
  endtask

  task automatic send_run(input int src, input int dx, input int dy, input int tag, input logic [FW-1:0] second);
    int o;
    o = xy_port(dx, dy);
    sq_add(src, hd(2'b00, tag, dx, dy));
    sq_add(src, second);
    ex_add(o, hd(2'b00, tag, dx, dy));
    ex_add(o, second);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    out_ready = '1;
    for (int p = 0; p < NP; p++) begin
      sn[p] = 0; si[p] = 0; rn[p] = 0; en[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_all(input int lim);
    for (int k = 0; k < lim; k++) begin
      bit done = 1'b1;
      for (int p = 0; p < NP; p++) if (rn[p] < en[p]) done = 1'b0;
      if (done) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_all(input string rq);
    for (int o = 0; o < NP; o++) begin
      chk(rn[o] == en[o], rq, rn[o], en[o]);
      for (int k = 0; k < en[o] && k < rn[o]; k++)
        chk(rec[o][k] == ex[o][k], rq, rec[o][k], ex[o][k]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid == '0, "R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == '1, "R1 ready after reset", in_ready, 5'h1f);
    chk(out_valid == '0, "R1 valid after reset", out_valid, 0);
  endtask

  task automatic t_route();
    int c0;
    do_reset();
    send_run(0, 3, 1, 1, 12'h401);
    send_run(0, 0, 1, 2, 12'hC02);
    send_run(0, 1, 3, 3, 12'h003);
    send_run(0, 1, 0, 4, 12'h804);
    send_run(0, 1, 1, 5, 12'h405);
    send_run(0, 2, 0, 6, 12'hC06);
    send_run(0, 0, 2, 7, 12'h407);
    wait_all(300);
    cmp_all("R3/R4 routing");
    do_reset();
    send_run(0, 3, 3, 8, 12'h111);
    c0 = cyc;
    wait_all(50);
    cmp_all("R12 route");
    chk(rcyc[2][0] == c0 + 2, "R12 latency", rcyc[2][0] - c0, 2);
  endtask

  task automatic t_frame();
    do_reset();
    sq_add(4, hd(2'b01, 1, 3, 1)); sq_add(4, 12'h0AA); sq_add(4, 12'h4BB);
    sq_add(4, 12'h8CC); sq_add(4, 12'hCDD);
    sq_add(4, hd(2'b00, 2, 3, 1)); sq_add(4, 12'h3EE);
    sq_add(3, hd(2'b01, 3, 3, 1)); sq_add(3, 12'h411); sq_add(3, 12'hC22);
    sq_add(3, hd(2'b10, 4, 3, 1));
    sq_add(3, hd(2'b00, 5, 3, 1)); sq_add(3, 12'hC33);
    ex_add(2, hd(2'b01, 3, 3, 1)); ex_add(2, 12'h411); ex_add(2, 12'hC22);
    ex_add(2, hd(2'b01, 1, 3, 1)); ex_add(2, 12'h0AA); ex_add(2, 12'h4BB);
    ex_add(2, 12'h8CC); ex_add(2, 12'hCDD);
    ex_add(2, hd(2'b10, 4, 3, 1));
    ex_add(2, hd(2'b00, 2, 3, 1)); ex_add(2, 12'h3EE);
    ex_add(2, hd(2'b00, 5, 3, 1)); ex_add(2, 12'hC33);
    wait_all(300);
    cmp_all("R5/R6/R7/R8 framing");
  endtask

  task automatic t_rr();
    do_reset();
    for (int r = 0; r < 2; r++) begin
      for (int s = 1; s <= 3; s++) begin
        sq_add(s, hd(2'b00, 16*r + s, 1, 1));
        sq_add(s, 12'(12'h400 + 16*r + s));
      end
    end
    for (int r = 0; r < 2; r++) begin
      for (int s = 1; s <= 3; s++) begin
        ex_add(0, hd(2'b00, 16*r + s, 1, 1));
        ex_add(0, 12'(12'h400 + 16*r + s));
      end
    end
    wait_all(300);
    cmp_all("R8 order");
    chk(rcyc[0][11] - rcyc[0][0] == 11, "R11 no bubble", rcyc[0][11] - rcyc[0][0], 11);
  endtask

  task automatic t_bp();
    logic [FW-1:0] h0;
    do_reset();
    out_ready[2] = 1'b0;
    h0 = hd(2'b00, 9, 3, 1);
    send_run(0, 3, 1, 9, 12'h4A1);
    send_run(0, 3, 1, 10, 12'hCA2);
    send_run(0, 3, 1, 11, 12'h0A3);
    repeat (10) @(negedge clk);
    chk(in_ready[0] == 1'b0, "R2 ready low when full", in_ready[0], 0);
    chk(out_valid[2] == 1'b1, "R9 valid held", out_valid[2], 1);
    chk(out_flit[2*FW +: FW] == h0, "R9 flit held", out_flit[2*FW +: FW], h0);
    chk(rn[2] == 0, "R9 no transfer", rn[2], 0);
    repeat (3) @(negedge clk);
    chk(out_flit[2*FW +: FW] == h0 && out_valid[2], "R9 still held", out_flit[2*FW +: FW], h0);
    chk(in_ready[0] == 1'b0, "R2 still full", in_ready[0], 0);
    out_ready[2] = 1'b1;
    wait_all(300);
    cmp_all("R2 no loss");
  endtask

  task automatic t_par();
    do_reset();
    send_run(1, 1, 0, 12, 12'h4C1);
    send_run(4, 3, 1, 13, 12'h8C2);
    wait_all(100);
    cmp_all("R10/R3 parallel");
    chk(rcyc[3][0] == rcyc[2][0], "R10 same cycle", rcyc[3][0], rcyc[2][0]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      sn[p] = 0; si[p] = 0; rn[p] = 0; en[p] = 0;
    end
    fork
      drive(0); drive(1); drive(2); drive(3); drive(4);
    join_none
    t_reset();
    t_route();
    t_frame();
    t_rr();
    t_bp();
    t_par();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule